// File: doc/BRIEF.md
# Cellular Automaton Random Generator

This block produces 32-bit pseudo-random words. It does this by evolving a circular, one-dimensional cellular automaton by one generation for each word it emits. Each cell's next value depends only on that cell and its two immediate neighbours, and the ring wraps around at both ends.

A single-cycle start pulse loads a seed, a word count and a rule selection from plain input ports. The block then delivers exactly that many words on a valid/ready stream. The stream runs at one word per clock cycle while the consumer accepts, and holds steady while the consumer stalls. A one-cycle done pulse marks the end of the run.

Two neighbourhood rules are available:
- **Default rule:** each new cell is its left neighbour XOR (itself OR its right neighbour).
- **Alternate rule:** the left neighbour is inverted before the XOR.

Top module: `ca_rng`

## Requirements
- R1: With `rule_sel` = 0, new cell j equals cell (j-1) XOR (cell j OR cell (j+1)). Seed 2 therefore yields the first word 0x00000007.
- R2: With `rule_sel` = 1, new cell j equals NOT cell (j-1) XOR (cell j OR cell (j+1)). Seed 0 therefore yields the first word 0xFFFFFFFF.
- R3: Neighbours wrap around the ring. Cell 0's left neighbour is cell 31, and cell 31's right neighbour is cell 0. Under rule 0, seed 0x00000001 gives 0x80000003 and seed 0x80000000 gives 0xC0000001.
- R4: The seed itself is never emitted. The first word is the generation computed from the seed, and each later word is the generation computed from the word before it.
- R5: A run emits exactly `count` words. A count of zero emits none and still pulses `done` in the cycle after the start.
- R6: With `out_ready` held high, the words of a run appear in consecutive cycles. `out_valid` rises in the cycle after the start, and `done` follows `count` cycles after that.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the last word is accepted.
- R9: A start pulse while `out_valid` is high is ignored. The word sequence, its length and its rule are unaffected.
- R10: While `rst` is high, `out_valid` and `done` go low and `out_data` goes to zero. This clears any run in progress.
- R11: The rule is captured at start. Changing `rule_sel`, `seed` or `count` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| seed | input | WIDTH | Initial ring state, sampled at start |
| count | input | CNT_W | Number of words to emit, sampled at start |
| rule_sel | input | 1 | 0 = default rule, 1 = inverted-left rule; sampled at start |
| out_data | output | WIDTH | Current generation |
| out_valid | output | 1 | `out_data` holds an unaccepted word |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The main function is tried with several stimulus patterns, and each separates a different class of fault:
- **Seed 2 under both rules, with counts from one to two hundred:** compares the chained sequence against a behavioural ring model. An off-by-one in the count or a seed that leaks into the output shows up as a shifted sequence.
- **Single-bit seeds at each end of the ring:** expose a broken wrap-around connection, which the seed-2 runs barely exercise.
- **A zero seed under the inverted rule:** turns on every cell, which isolates the inversion itself.
- **Random backpressure plus stray start, seed and rule activity during runs:** shows whether stalls hold the word, and whether anything sampled only at start is wrongly taken live.

// File: rtl/ca_rng_pkg.sv
package ca_rng_pkg;

  typedef enum logic {
    RULE_XOR_OR   = 1'b0,
    RULE_INV_LEFT = 1'b1
  } rule_e;

endpackage

// File: rtl/ca_next_gen.sv
// Combinational one-generation step of a circular automaton ring.
module ca_next_gen
  import ca_rng_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  input  rule_e            rule,
  output logic [WIDTH-1:0] nxt
);

  logic inv_left;
  assign inv_left = (rule == RULE_INV_LEFT);

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    localparam int LEFT  = (j + WIDTH - 1) % WIDTH;
    localparam int RIGHT = (j + 1) % WIDTH;
    assign nxt[j] = (cur[LEFT] ^ inv_left) ^ (cur[j] | cur[RIGHT]);
  end

endmodule

// File: rtl/ca_run_ctrl.sv
// Run control: remaining-word counter, stream valid and done pulse.
module ca_run_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             ready,
  output logic             valid,
  output logic             done,
  output logic             load,
  output logic             step
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] remain_q;
  logic             valid_q;
  logic             done_q;
  logic             accept;
  logic             fire;
  logic             last;

  assign accept = start && !valid_q;
  assign fire   = valid_q && ready;
  assign last   = (remain_q == ONE);
  assign load   = accept && (count != ZERO);
  assign step   = fire && !last;
  assign valid  = valid_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= ZERO;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        remain_q <= remain_q - ONE;
        if (last) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end else if (accept) begin
        remain_q <= count;
        valid_q  <= (count != ZERO);
        done_q   <= (count == ZERO);
      end
    end
  end

endmodule

// File: rtl/ca_rng.sv
// Top: cellular automaton word generator with valid/ready output.
module ca_rng
  import ca_rng_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] seed,
  input  logic [CNT_W-1:0] count,
  input  logic             rule_sel,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done
);

  logic             load;
  logic             step;
  logic [WIDTH-1:0] data_q;
  rule_e            rule_q;
  logic [WIDTH-1:0] gen_src;
  rule_e            gen_rule;
  logic [WIDTH-1:0] gen_nxt;

  ca_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .count (count),
    .ready (out_ready),
    .valid (out_valid),
    .done  (done),
    .load  (load),
    .step  (step)
  );

  // A new run steps from the seed with the freshly selected rule;
  // otherwise the current word and the captured rule feed the step.
  assign gen_src  = load ? seed : data_q;
  assign gen_rule = load ? rule_e'(rule_sel) : rule_q;

  ca_next_gen #(.WIDTH(WIDTH)) u_gen (
    .cur  (gen_src),
    .rule (gen_rule),
    .nxt  (gen_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rule_q <= RULE_XOR_OR;
    end else if (load) begin
      data_q <= gen_nxt;
      rule_q <= rule_e'(rule_sel);
    end else if (step) begin
      data_q <= gen_nxt;
    end
  end

  assign out_data = data_q;

endmodule

// File: rtl/ca_rng_chk.sv
module ca_rng_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic [WIDTH-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             done
);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready) || $past(start && !out_valid && count == '0));

  // R5
  after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> out_valid || done);

  // R9
  idle_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !start |=> !out_valid);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !done && out_data == '0);

endmodule

bind ca_rng ca_rng_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .count     (count),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done)
);

// File: tb/sim_ca_rng.sv
`timescale 1ns/1ps
module sim_ca_rng;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] seed = '0;
  logic [31:0] count = '0;
  logic        rule_sel = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        done;

  always #10 clk = ~clk;

  ca_rng #(.WIDTH(32), .CNT_W(32)) u0 (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .count(count),
    .rule_sel(rule_sel), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done)
  );

  int    total = 0;
  int    bad = 0;
  int    acc = 0;
  int    edges = 0;
  bit    finished = 0;
  string tag = "R10";

  // behavioural model state
  bit          m_valid = 0;
  bit          m_done = 0;
  bit          m_rule = 0;
  logic [31:0] m_word = '0;
  longint      m_left = 0;

  function automatic logic [31:0] ref_step(input logic [31:0] s, input bit r);
    logic [31:0] n;
    n = '0;
    for (int j = 0; j < 32; j++) begin
      int  l;
      int  rr;
      bit  a;
      l  = (j + 31) % 32;
      rr = (j + 1) % 32;
      a  = s[l];
      if (r) a = !a;
      n[j] = a ^ (s[j] | s[rr]);
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    edges++;
    if (rst) begin
      m_valid = 0; m_done = 0; m_word = '0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_valid && out_ready) begin
        m_left--;
        if (m_left == 0) begin
          m_valid = 0; m_done = 1;
        end else begin
          m_word = ref_step(m_word, m_rule);
        end
      end else if (!m_valid && start) begin
        m_rule = rule_sel;
        if (count == 0) m_done = 1;
        else begin
          m_valid = 1; m_left = count; m_word = ref_step(seed, rule_sel);
        end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #1;
    if (edges > 0 && !finished) begin
      check(out_valid == m_valid, "R5", "valid", 64'(out_valid), 64'(m_valid));
      check(done == m_done, "R8", "done", 64'(done), 64'(m_done));
      if (m_valid)
        check(out_data == m_word, tag, "word", 64'(out_data), 64'(m_word));
      if (out_valid && out_ready) acc++;
    end
  end

  task automatic run(input logic [31:0] sd, input int n, input bit md, input int bp,
                     input bit junk, input bit chk_first, input logic [31:0] first_exp,
                     input string t);
    int cyc;
    tag = t;
    @(negedge clk);
    acc = 0;
    seed = sd; count = n; rule_sel = md; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    if (chk_first)
      check(out_valid && out_data == first_exp, t, "first word", 64'(out_data), 64'(first_exp));
    while (!done && cyc < 5000) begin
      out_ready = (bp == 0) ? 1'b1 : ($urandom_range(99) >= bp);
      if (junk && m_valid) begin
        start = $urandom_range(1); seed = $urandom; rule_sel = $urandom_range(1);
        count = $urandom;
      end
      @(negedge clk);
      start = 0;
      cyc++;
    end
    check(acc == n, "R5", "word count", 64'(acc), 64'(n));
    if (bp == 0) check(cyc == n, "R6", "cycles to done", 64'(cyc), 64'(n));
    @(negedge clk);
    check(done == 0, "R8", "done width", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !done && out_data == 0, "R10", "reset state",
          {out_valid, done, out_data}, 64'd0);
    rst = 0;
    out_ready = 1;
    run(32'd2, 1, 0, 0, 0, 1, 32'h0000_0007, "R1");
    run(32'd2, 7, 0, 0, 0, 1, 32'h0000_0007, "R4");
    run(32'd2, 40, 0, 30, 0, 0, 0, "R4");
    run(32'h0000_0001, 5, 0, 0, 0, 1, 32'h8000_0003, "R3");
    run(32'h8000_0000, 3, 0, 0, 0, 1, 32'hC000_0001, "R3");
    run(32'd0, 4, 1, 0, 0, 1, 32'hFFFF_FFFF, "R2");
    run(32'd2, 30, 1, 40, 0, 0, 0, "R2");
    run(32'd2, 0, 0, 0, 0, 0, 0, "R5");
    run(32'd2, 64, 0, 0, 0, 0, 0, "R6");
    run(32'd2, 200, 0, 60, 0, 0, 0, "R7");
    run(32'd2, 120, 0, 35, 1, 0, 0, "R9");
    run(32'd2, 90, 1, 20, 1, 0, 0, "R11");
    // mid-run reset
    tag = "R10";
    @(negedge clk);
    seed = 32'd2; count = 50; rule_sel = 0; start = 1; out_ready = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(!out_valid && !done && out_data == 0, "R10", "cleared mid-run",
          {out_valid, done, out_data}, 64'd0);
    rst = 0;
    run(32'd2, 9, 0, 0, 0, 1, 32'h0000_0007, "R1");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule